// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a serial-bus slave that lets an external host read and write a bank of 8-bit control registers. It oversamples SCL and SDA on the system clock and finds START and STOP conditions. It checks the 7-bit device address and then walks a sub-address pointer through the register space. The registers are outside the block. The block reaches them through a single-cycle port with an address, write data, a write strobe, a read strobe and read data that the register bank returns combinationally. SDA is driven as open drain: the block only ever asks for the line to be pulled low.

A write transaction carries the sub-address in its second byte, and every byte after that goes to the register the pointer selects. A read transaction has no sub-address phase. It starts at the pointer left by the last write and keeps sending bytes while the host acknowledges. The pointer steps forward after every byte, in both directions, and a START or STOP leaves it unchanged.

Top module: `i2c_reg_port`

## Requirements
- R1: The block acknowledges a first byte whose upper seven bits equal the device address (default 1000000b). Bit 0 of that byte selects the direction, with 1 meaning read and 0 meaning write.
- R2: When the address does not match, the block drives no acknowledge and makes no register access for any later byte until the next START or STOP.
- R3: In a write, the byte after the address is loaded as the pointer. Each further byte causes exactly one single-cycle write strobe, with the address equal to the pointer and the write data equal to the received byte. Every byte is acknowledged.
- R4: After each written byte the pointer rises by one and wraps from the top address to zero.
- R5: A read returns the register at the current pointer, MSB first. The first bit is on SDA before the first SCL rise of the data byte.
- R6: After each byte sent the pointer rises by one. The next byte follows while the host acknowledges. After a not-acknowledge the block releases SDA.
- R7: A START or STOP at any bit position returns the block to address reception or idle. A partly received byte is never written, and the pointer keeps its value.
- R8: The block changes its SDA drive only while SCL is low, and it holds the acknowledge low through the ninth SCL high period.
- R9: After reset the block drives SDA not at all, asserts no strobe and holds the pointer at zero.
- R10: The read strobe lasts one cycle per byte sent and is never asserted together with the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| regAddr | output | ADDR_W | Register address, equal to the pointer |
| regWrData | output | 8 | Byte to write |
| regWrEn | output | 1 | Single-cycle write strobe |
| regRdData | input | 8 | Register contents at regAddr |
| regRdEn | output | 1 | Single-cycle read strobe, marking when regRdData is taken |

## Verification
The bench builds the block with an 8-bit pointer, the default device address and two synchronizer stages. With a quarter SCL period of eight system clocks, the bus runs at a 32:1 ratio. The 8-bit pointer puts the wrap from 0xFF to 0x00 within a three-byte burst. The short synchronizer keeps the edge-detect latency small next to the SCL low time, so SDA drive changes can be tied closely to SCL low. A behavioural model holds its own copy of the register contents and the pointer. It queues the expected write strobes and compares them on every clock while the bench runs repeated starts, wrong addresses and a STOP in the middle of a byte.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_MACK,
    ST_IGNORE
  } busState_t;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic shiftRx;   // shift in sampled SDA, count bit
    logic shiftTx;   // shift out next bit, count bit
    logic loadTx;    // take regRdData into shifter
    logic cntClr;    // clear bit counter
    logic ptrLoad;   // pointer <= received byte
    logic ptrInc;    // pointer + 1
    logic wrStb;     // register write strobe
    logic rdStb;     // register read strobe
    logic ackOn;     // pull SDA low for acknowledge
    logic sdaOff;    // release SDA
  } ctlStrobe_t;

endpackage

// File: rtl/i2c_reg_datapath.sv
module i2c_reg_datapath
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  ctlStrobe_t              ctl,
  input  logic [BYTE_W-1:0]       regRdData,
  output logic                    sclRise,
  output logic                    sclFall,
  output logic                    startSeen,
  output logic                    stopSeen,
  output logic                    sdaBit,
  output logic [CNT_W-1:0]        bitCnt,
  output logic [BYTE_W-1:0]       rxByte,
  output logic [ADDR_W-1:0]       regAddr,
  output logic [BYTE_W-1:0]       regWrData,
  output logic                    regWrEn,
  output logic                    regRdEn,
  output logic                    sdaDriveLow
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]        sclPipe, sdaPipe;
  logic                 sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0]    shiftReg;
  logic [ADDR_W-1:0]    ptr;
  logic                 sdaLow;

  // multi-stage synchronizer; bus idles high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[LAST-1:0], sclIn};
          sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[LAST];
  assign sdaS = sdaPipe[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sdaBit    = sdaS;

  // shared receive/transmit shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.loadTx) begin
      shiftReg <= regRdData;
    end else if (ctl.shiftRx) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
    end else if (ctl.shiftTx) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) begin
      bitCnt <= '0;
    end else if (ctl.shiftRx || ctl.shiftTx) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctl.ptrLoad) begin
      ptr <= ADDR_W'(shiftReg);
    end else if (ctl.ptrInc) begin
      ptr <= ptr + ADDR_W'(1);
    end
  end

  // open-drain pull-down request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaLow <= 1'b0;
    end else if (ctl.ackOn) begin
      sdaLow <= 1'b1;
    end else if (ctl.sdaOff) begin
      sdaLow <= 1'b0;
    end else if (ctl.loadTx) begin
      sdaLow <= ~regRdData[BYTE_W-1];
    end else if (ctl.shiftTx) begin
      sdaLow <= ~shiftReg[BYTE_W-2];
    end
  end

  assign rxByte      = shiftReg;
  assign regAddr     = ptr;
  assign regWrData   = shiftReg;
  assign regWrEn     = ctl.wrStb;
  assign regRdEn     = ctl.rdStb;
  assign sdaDriveLow = sdaLow;

endmodule

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startSeen,
  input  logic               stopSeen,
  input  logic               sdaBit,
  input  logic [CNT_W-1:0]   bitCnt,
  input  logic [BYTE_W-1:0]  rxByte,
  output ctlStrobe_t         ctl
);

  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

  busState_t state, stateNxt;
  logic      readMode, readModeNxt;
  logic      hostAck, hostAckNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      readMode <= 1'b0;
      hostAck  <= 1'b0;
    end else begin
      state    <= stateNxt;
      readMode <= readModeNxt;
      hostAck  <= hostAckNxt;
    end
  end

  always_comb begin
    ctl         = '0;
    stateNxt    = state;
    readModeNxt = readMode;
    hostAckNxt  = hostAck;
    if (startSeen) begin
      stateNxt   = ST_ADDR;
      ctl.cntClr = 1'b1;
      ctl.sdaOff = 1'b1;
    end else if (stopSeen) begin
      stateNxt   = ST_IDLE;
      ctl.cntClr = 1'b1;
      ctl.sdaOff = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (sclRise && bitCnt < FULL_BYTE) begin
            ctl.shiftRx = 1'b1;
          end else if (sclFall && bitCnt == FULL_BYTE) begin
            ctl.cntClr = 1'b1;
            if (state == ST_ADDR) begin
              if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
                ctl.ackOn   = 1'b1;
                readModeNxt = rxByte[0];
                stateNxt    = ST_ADDR_ACK;
              end else begin
                stateNxt = ST_IGNORE;
              end
            end else if (state == ST_SUB) begin
              ctl.ptrLoad = 1'b1;
              ctl.ackOn   = 1'b1;
              stateNxt    = ST_SUB_ACK;
            end else begin
              ctl.wrStb  = 1'b1;
              ctl.ptrInc = 1'b1;
              ctl.ackOn  = 1'b1;
              stateNxt   = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (readMode) begin
              ctl.loadTx = 1'b1;
              ctl.rdStb  = 1'b1;
              ctl.cntClr = 1'b1;
              stateNxt   = ST_RDATA;
            end else begin
              ctl.sdaOff = 1'b1;
              stateNxt   = ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            ctl.sdaOff = 1'b1;
            stateNxt   = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              ctl.sdaOff = 1'b1;
              ctl.ptrInc = 1'b1;
              stateNxt   = ST_MACK;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            hostAckNxt = ~sdaBit;
          end else if (sclFall) begin
            if (hostAck) begin
              ctl.loadTx = 1'b1;
              ctl.rdStb  = 1'b1;
              ctl.cntClr = 1'b1;
              stateNxt   = ST_RDATA;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h40,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn,
  input  logic [7:0]        regRdData,
  output logic              regRdEn
);

  ctlStrobe_t          ctl;
  logic                sclRise, sclFall, startSeen, stopSeen, sdaBit;
  logic [CNT_W-1:0]    bitCnt;
  logic [BYTE_W-1:0]   rxByte;

  i2c_reg_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .sdaBit(sdaBit), .bitCnt(bitCnt), .rxByte(rxByte),
    .ctl(ctl)
  );

  i2c_reg_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .regRdData(regRdData),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .sdaBit(sdaBit), .bitCnt(bitCnt), .rxByte(rxByte),
    .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2c_reg_port_chk.sv
module i2c_reg_port_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaDriveLow,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              regRdEn
);

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  assert_ptr_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == ADDR_W'($past(regAddr) + 1'b1)));

  assert_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

  assert_rd_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

endmodule

bind i2c_reg_port i2c_reg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/i2c_reg_port_bench.sv
module i2c_reg_port_bench;

  localparam int QTR = 8;
  localparam logic [6:0] DEV = 7'h40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData;
  wire  sdaBus = sdaM & ~sdaDriveLow;

  logic [7:0] mem [256];
  int modelMem [256];
  int modelPtr = 0;
  int expWr [$];
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  i2c_reg_port u_i2c_reg_port (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .regRdEn(regRdEn)
  );

  function automatic int pat(int i);
    return (i * 7 + 3) & 255;
  endfunction

  // register bank outside the block
  always_comb regRdData = mem[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(pat(i));
    end else if (regWrEn) begin
      mem[regAddr] <= regWrData;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of write strobes against the model queue
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expWr.size() == 0) begin
        check(1'b0, "R3 unexpected write", {regAddr, regWrData}, 0);
      end else begin
        int e;
        e = expWr.pop_front();
        check({24'd0, regAddr, regWrData} == e, "R3 write strobe", {regAddr, regWrData}, e);
      end
    end
    if (rstN && regWrEn && regRdEn) check(1'b0, "R10 strobes overlap", 1, 0);
  end

  task automatic qw();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; qw(); sclM = 1'b1; qw(); sdaM = 1'b0; qw(); sclM = 1'b0; qw();
  endtask

  task automatic busStop();
    sdaM = 1'b0; qw(); sclM = 1'b1; qw(); sdaM = 1'b1; qw();
  endtask

  task automatic putBit(input bit b);
    sdaM = b; qw(); sclM = 1'b1; qw(); qw(); sclM = 1'b0; qw();
  endtask

  task automatic getBit(output bit b);
    sdaM = 1'b1; qw(); sclM = 1'b1; qw(); b = sdaBus; qw(); sclM = 1'b0; qw();
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    bit r;
    for (int i = 7; i >= 0; i--) putBit(d[i]);
    getBit(r);
    acked = !r;
  endtask

  task automatic recvByte(output logic [7:0] d, input bit giveAck);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      d[i] = b;
    end
    putBit(!giveAck);
  endtask

  task automatic writeRegs(input int sub, input int n, input int seed, input bit doStop);
    bit a;
    int d;
    busStart();
    sendByte({DEV, 1'b0}, a);
    check(a, "R1 write address ack", a, 1);
    sendByte(8'(sub), a);
    check(a, "R3 sub-address ack", a, 1);
    modelPtr = sub;
    for (int k = 0; k < n; k++) begin
      d = (seed + k * 37) & 255;
      expWr.push_back((modelPtr << 8) | d);
      modelMem[modelPtr] = d;
      sendByte(8'(d), a);
      check(a, "R3 data ack", a, 1);
      modelPtr = (modelPtr + 1) & 255;   // R4 increment with wrap
    end
    if (doStop) busStop();
    check(expWr.size() == 0, "R3 R4 all writes seen", expWr.size(), 0);
  endtask

  task automatic readRegs(input int n, input string req);
    bit a;
    logic [7:0] d;
    busStart();
    sendByte({DEV, 1'b1}, a);
    check(a, "R1 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(d, k < n - 1);
      check(int'(d) == modelMem[modelPtr], req, d, modelMem[modelPtr]);
      modelPtr = (modelPtr + 1) & 255;
    end
    repeat (4) @(negedge clk);
    check(sdaDriveLow == 1'b0, "R6 released after nack", sdaDriveLow, 0);
    busStop();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    finishRun();
  end

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) modelMem[i] = pat(i);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(sdaDriveLow == 1'b0, "R9 no drive", sdaDriveLow, 0);
    check(regWrEn == 1'b0 && regRdEn == 1'b0, "R9 no strobes", {regWrEn, regRdEn}, 0);
    check(regAddr == 8'h00, "R9 pointer zero", regAddr, 0);
    readRegs(2, "R9 R5 read from reset pointer");

    // R3 R4 burst write, then sub-address only, then reads (R5 R6)
    writeRegs(8'h10, 3, 8'h5A, 1'b1);
    writeRegs(8'h20, 0, 0, 1'b1);
    readRegs(3, "R5 R6 burst read");
    readRegs(1, "R6 pointer carried across reads");
    readRegs(2, "R6 second read");

    // R7 repeated start moves straight into a read
    writeRegs(8'h11, 0, 0, 1'b0);
    readRegs(2, "R7 read after repeated start");

    // R2 wrong address: no ack, no access
    busStart();
    sendByte({7'h42, 1'b0}, a);
    check(!a, "R2 no ack on wrong address", a, 0);
    sendByte(8'h00, a);
    check(!a, "R2 later byte ignored", a, 0);
    sendByte(8'h55, a);
    check(!a, "R2 later byte ignored", a, 0);
    busStop();
    readRegs(1, "R2 pointer untouched");

    // R4 wrap from top address
    writeRegs(8'hFE, 3, 8'h91, 1'b1);
    check(modelPtr == 1, "R4 model wrap", modelPtr, 1);
    readRegs(1, "R4 read after wrap");

    // R7 stop in the middle of a byte
    busStart();
    sendByte({DEV, 1'b0}, a);
    check(a, "R1 address ack", a, 1);
    sendByte(8'h30, a);
    check(a, "R3 sub-address ack", a, 1);
    modelPtr = 8'h30;
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b1);
    busStop();
    repeat (4) @(negedge clk);
    check(regAddr == 8'h30, "R7 pointer kept after abort", regAddr, 8'h30);
    readRegs(2, "R7 no write from partial byte");

    repeat (20) @(negedge clk);
    finishRun();
  end

endmodule